// File: doc/BRIEF.md
# Volume Ramp and Power Mode Sequencer

This block drives the applied digital volume of an audio power amplifier and decides when the output stage may switch. Software programs a target level. Separate controls request shutdown, sleep or mute. The block moves the applied level one 0.5 dB code at a time, paced by the audio sample strobe, so that level changes never become audible steps.

The power controls are interlocked with this ramp. Leaving shutdown waits a long start-up delay before switching begins. Sleep and shutdown first bring the applied level down to the floor, and only then stop switching, after a short settle time. Waking from sleep restarts switching after the same short delay. Every start of switching begins at the floor and climbs from there. A millisecond tick times the delays.

Volume codes are unsigned. Code 0 is the −100 dB floor, and each increment adds 0.5 dB, so code 200 is 0 dB.

Top module: `vramp_seq_top`

## Requirements
- R1: Once both shutdown sources are low and sleep is low, `sw_en_o` rises 25 ms ticks later. While sleep is held high, switching does not start.
- R2: Whenever `sw_en_o` rises, `vol_o` is code 0 (−100 dB). It then climbs toward the target.
- R3: `vol_o` changes only on a sample strobe, by exactly one code, and after eight strobes. It never changes by more than one code in a cycle.
- R4: A full climb from code 0 to code 200 takes 1600 sample strobes.
- R5: With mute high, `vol_o` ramps to code 0 at the normal rate while `sw_en_o` stays high. Clearing mute ramps it back up to the programmed target.
- R6: Sleep or shutdown first ramps `vol_o` to code 0 with switching still on. `sw_en_o` falls one to two ms ticks after the floor is reached, and `vol_o` is 0 whenever `sw_en_o` is low.
- R7: Clearing sleep restarts switching one to two ms ticks later, with no long start-up delay. The climb then begins from code 0.
- R8: Shutdown is requested when `shdn_pin_i` or `shdn_reg_i` is high. Leaving shutdown needs both of them low.
- R9: A target change during play makes `vol_o` step toward the new value at one code per eight strobes, in either direction.
- R10: A mute or unmute during a ramp reverses it from the current level, without returning to code 0.
- R11: Any change of the level being approached clears the eight-strobe pace counter. The first step comes exactly eight strobes after the change.
- R12: `ramping_o` is high exactly when `vol_o` differs from the level it is approaching, which is 0 under mute, sleep or shutdown and the target otherwise.
- R13: After reset `vol_o` is 0, and `sw_en_o` and `ramping_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vol_target_i | input | VOL_W | Programmed volume code |
| shdn_pin_i | input | 1 | Shutdown request from the pin |
| shdn_reg_i | input | 1 | Shutdown request from the control register |
| sleep_i | input | 1 | Sleep request |
| mute_i | input | 1 | Mute request |
| sample_stb_i | input | 1 | One-cycle pulse per audio sample |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| vol_o | output | VOL_W | Applied volume code |
| sw_en_o | output | 1 | Output stage switching enable |
| ramping_o | output | 1 | Applied level differs from the level being approached |

## Verification
The assertions check the per-cycle invariants on every cycle: the level moves one code at most and only on a strobe, switching starts and stops only at the floor, no start happens under a shutdown request, and every level change happens while ramping is flagged. The bench scenarios cover what depends on counts and history. These are the 25 ms and 1 ms delays, the exact eight-strobe pace after a change, the 1600-strobe full climb, a reversal that does not fall back to the floor, and the need to release both shutdown sources.

// File: rtl/vramp_pkg.sv
package vramp_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_START = 3'd1,
    ST_PLAY  = 3'd2,
    ST_DOWN  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_SLEEP = 3'd5,
    ST_WAKE  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/vramp_ms_timer.sv
module vramp_ms_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vramp_ramp.sv
module vramp_ramp #(
  parameter int VOL_W        = 8,
  parameter int STEP_SAMPLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [VOL_W-1:0] goal_i,
  input  logic             stb_i,
  output logic [VOL_W-1:0] vol_o,
  output logic             busy_o
);
  localparam int PACE_W = (STEP_SAMPLES > 2) ? $clog2(STEP_SAMPLES) : 1;
  localparam logic [PACE_W-1:0] PACE_LAST = PACE_W'(STEP_SAMPLES - 1);

  logic [VOL_W-1:0]  vol_q, goal_q;
  logic [PACE_W-1:0] pace_q;
  logic              goal_moved, at_goal, go_up;

  assign goal_moved = (goal_i != goal_q);
  assign at_goal    = (vol_q == goal_i);
  assign go_up      = (vol_q < goal_i);
  assign vol_o      = vol_q;
  assign busy_o     = !at_goal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q  <= '0;
      goal_q <= '0;
      pace_q <= '0;
    end else begin
      goal_q <= goal_i;
      if (!run_i) begin
        vol_q  <= '0;
        pace_q <= '0;
      end else if (goal_moved || at_goal) begin
        pace_q <= '0;
      end else if (stb_i) begin
        if (pace_q == PACE_LAST) begin
          pace_q <= '0;
          vol_q  <= go_up ? vol_q + 1'b1 : vol_q - 1'b1;
        end else begin
          pace_q <= pace_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vramp_mode_fsm.sv
module vramp_mode_fsm
  import vramp_pkg::*;
#(
  parameter int TMR_W      = 5,
  parameter int STARTUP_MS = 25,
  parameter int SETTLE_MS  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shdn_req_i,
  input  logic             sleep_i,
  input  logic             mute_i,
  input  logic             at_floor_i,
  input  logic             tmr_done_i,
  output logic             tmr_clear_o,
  output logic [TMR_W-1:0] tmr_limit_o,
  output logic             run_o,
  output logic             floor_goal_o
);
  seq_state_e state_q, state_d;
  logic       stay_on;

  assign stay_on = !shdn_req_i && !sleep_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (stay_on) state_d = ST_START;
      ST_START: begin
        if (!stay_on)        state_d = ST_OFF;
        else if (tmr_done_i) state_d = ST_PLAY;
      end
      ST_PLAY:  if (!stay_on) state_d = ST_DOWN;
      ST_DOWN: begin
        if (stay_on)         state_d = ST_PLAY;
        else if (at_floor_i) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (stay_on)         state_d = ST_PLAY;
        else if (tmr_done_i) state_d = shdn_req_i ? ST_OFF : ST_SLEEP;
      end
      ST_SLEEP: begin
        if (shdn_req_i)      state_d = ST_OFF;
        else if (!sleep_i)   state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (shdn_req_i)      state_d = ST_OFF;
        else if (sleep_i)    state_d = ST_SLEEP;
        else if (tmr_done_i) state_d = ST_PLAY;
      end
      default:               state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign tmr_clear_o  = (state_d != state_q);
  assign tmr_limit_o  = (state_q == ST_START) ? TMR_W'(STARTUP_MS) : TMR_W'(SETTLE_MS);
  assign run_o        = (state_q == ST_PLAY) || (state_q == ST_DOWN) || (state_q == ST_HOLD);
  assign floor_goal_o = (state_q != ST_PLAY) || mute_i;
endmodule

// File: rtl/vramp_seq_top.sv
module vramp_seq_top #(
  parameter int VOL_W        = 8,
  parameter int STEP_SAMPLES = 8,
  parameter int STARTUP_MS   = 25,
  parameter int SETTLE_MS    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VOL_W-1:0] vol_target_i,
  input  logic             shdn_pin_i,
  input  logic             shdn_reg_i,
  input  logic             sleep_i,
  input  logic             mute_i,
  input  logic             sample_stb_i,
  input  logic             ms_tick_i,
  output logic [VOL_W-1:0] vol_o,
  output logic             sw_en_o,
  output logic             ramping_o
);
  localparam int MAX_MS = (STARTUP_MS > SETTLE_MS) ? STARTUP_MS : SETTLE_MS;
  localparam int TMR_W  = $clog2(MAX_MS + 1);

  logic             shdn_req, run, floor_goal, tmr_clear, tmr_done;
  logic [TMR_W-1:0] tmr_limit;
  logic [VOL_W-1:0] goal, vol;

  assign shdn_req = shdn_pin_i | shdn_reg_i;
  assign goal     = floor_goal ? '0 : vol_target_i;

  vramp_mode_fsm #(
    .TMR_W(TMR_W), .STARTUP_MS(STARTUP_MS), .SETTLE_MS(SETTLE_MS)
  ) i_fsm (
    .clk_i, .rst_ni,
    .shdn_req_i  (shdn_req),
    .sleep_i,
    .mute_i,
    .at_floor_i  (vol == '0),
    .tmr_done_i  (tmr_done),
    .tmr_clear_o (tmr_clear),
    .tmr_limit_o (tmr_limit),
    .run_o       (run),
    .floor_goal_o(floor_goal)
  );

  vramp_ms_timer #(.CNT_W(TMR_W)) i_tmr (
    .clk_i, .rst_ni,
    .clear_i(tmr_clear),
    .tick_i (ms_tick_i),
    .limit_i(tmr_limit),
    .done_o (tmr_done)
  );

  vramp_ramp #(.VOL_W(VOL_W), .STEP_SAMPLES(STEP_SAMPLES)) i_ramp (
    .clk_i, .rst_ni,
    .run_i (run),
    .goal_i(goal),
    .stb_i (sample_stb_i),
    .vol_o (vol),
    .busy_o(ramping_o)
  );

  assign vol_o   = vol;
  assign sw_en_o = run;
endmodule

// File: rtl/vramp_seq_chk.sv
module vramp_seq_chk #(
  parameter int VOL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shdn_pin_i,
  input logic             shdn_reg_i,
  input logic             sample_stb_i,
  input logic [VOL_W-1:0] vol_o,
  input logic             sw_en_o,
  input logic             ramping_o
);
  AST_ONE_CODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vol_o != $past(vol_o)) |-> ((vol_o == $past(vol_o) + 1'b1) || (vol_o == $past(vol_o) - 1'b1) || (vol_o == '0))); // R3
  AST_STEP_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && $past(sw_en_o) && (vol_o != $past(vol_o))) |-> $past(sample_stb_i)); // R3
  AST_START_AT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> (vol_o == '0)); // R2
  AST_STOP_AT_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_o) |-> ($past(vol_o) == '0)); // R6
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> (vol_o == '0)); // R6
  AST_NO_START_IN_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> !($past(shdn_pin_i) || $past(shdn_reg_i))); // R8
  AST_MOVE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && $past(sw_en_o) && (vol_o != $past(vol_o))) |-> $past(ramping_o)); // R12
endmodule

bind vramp_seq_top vramp_seq_chk #(.VOL_W(VOL_W)) i_vramp_chk (
  .clk_i, .rst_ni, .shdn_pin_i, .shdn_reg_i, .sample_stb_i,
  .vol_o, .sw_en_o, .ramping_o
);

// File: tb/test_vramp_seq_top.sv
module test_vramp_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int STB_DIV    = 4;
  localparam int TICK_DIV   = 16;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] target = 8'd200;
  logic       shdn_pin = 1'b1, shdn_reg = 1'b0, sleep = 1'b0, mute = 1'b0;
  logic       stb = 1'b0, tick = 1'b0;
  logic [7:0] vol;
  logic       sw_en, ramping;

  int checks = 0, fails = 0, jump_errs = 0;
  int strobes_seen = 0, ticks_seen = 0, cycles = 0;
  int stb_ph = 0, tick_ph = 0;
  logic [7:0] prev_vol = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vramp_seq_top i_vramp_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .vol_target_i(target),
    .shdn_pin_i(shdn_pin), .shdn_reg_i(shdn_reg), .sleep_i(sleep), .mute_i(mute),
    .sample_stb_i(stb), .ms_tick_i(tick),
    .vol_o(vol), .sw_en_o(sw_en), .ramping_o(ramping)
  );

  always @(posedge clk) begin
    if (stb)  strobes_seen <= strobes_seen + 1;
    if (tick) ticks_seen   <= ticks_seen + 1;
    stb_ph  <= (stb_ph == STB_DIV - 1) ? 0 : stb_ph + 1;
    tick_ph <= (tick_ph == TICK_DIV - 1) ? 0 : tick_ph + 1;
    stb     <= (stb_ph == STB_DIV - 2);
    tick    <= (tick_ph == TICK_DIV - 3);
    cycles  <= cycles + 1;
  end

  // R3: never more than one code per cycle
  always @(negedge clk) begin
    if (rst_n && sw_en) begin
      if ((vol > prev_vol + 8'd1) || (prev_vol > vol + 8'd1)) jump_errs++;
    end
    prev_vol = vol;
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_ticks(input int n);
    int t0 = ticks_seen;
    while (ticks_seen - t0 < n) @(negedge clk);
  endtask

  task automatic wait_vol(input int v);
    while (vol != 8'(v)) @(negedge clk);
  endtask

  // place the bench just after a strobe, so the next edge carries none
  task automatic sync_gap();
    @(negedge clk);
    while (!stb) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R13 vol", vol, 0);
    chk_eq("R13 sw_en", sw_en, 0);
    chk_eq("R13 ramping", ramping, 0);
  endtask

  task automatic t_startup();
    int t0, s0, sw_seen;
    sleep = 1'b1;
    shdn_pin = 1'b0;
    sw_seen = 0;
    t0 = ticks_seen;
    while (ticks_seen - t0 < 40) begin @(negedge clk); sw_seen |= int'(sw_en); end
    chk_eq("R1 held by sleep", sw_seen, 0);
    sleep = 1'b0;
    t0 = ticks_seen;
    while (!sw_en) @(negedge clk);
    chk_rng("R1 startup ticks", ticks_seen - t0, 24, 26);
    chk_eq("R2 start at floor", vol, 0);
    s0 = strobes_seen;
    wait_vol(1);
    chk_eq("R12 ramping up", ramping, 1);
    wait_vol(2);
    s0 = strobes_seen;
    wait_vol(3);
    chk_eq("R3 strobes per step", strobes_seen - s0, 8);
    wait_vol(200);
    @(negedge clk);
    chk_eq("R12 settled", ramping, 0);
  endtask

  task automatic t_full_ramp_timing();
    int s0;
    // mute from 200: exact full-span pace in both directions
    sync_gap();
    mute = 1'b1;
    s0 = strobes_seen;
    wait_vol(199);
    chk_eq("R11 first step after change", strobes_seen - s0, 8);
    wait_vol(0);
    chk_eq("R5 mute down strobes", strobes_seen - s0, 1600);
    chk_eq("R5 switching kept", sw_en, 1);
    @(negedge clk);
    chk_eq("R12 muted idle", ramping, 0);
    sync_gap();
    mute = 1'b0;
    s0 = strobes_seen;
    wait_vol(200);
    chk_eq("R4 full climb strobes", strobes_seen - s0, 1600);
  endtask

  task automatic t_reverse();
    int lo;
    sync_gap();
    mute = 1'b1;
    wait_vol(150);
    sync_gap();
    mute = 1'b0;
    lo = 150;
    while (vol != 8'd200) begin
      @(negedge clk);
      if (int'(vol) < lo) lo = int'(vol);
    end
    chk_rng("R10 reversal floor", lo, 149, 150);
  endtask

  task automatic t_target();
    int s0;
    sync_gap();
    target = 8'd180;
    s0 = strobes_seen;
    wait_vol(180);
    chk_eq("R9 step down strobes", strobes_seen - s0, 160);
    sync_gap();
    target = 8'd190;
    s0 = strobes_seen;
    wait_vol(190);
    chk_eq("R9 step up strobes", strobes_seen - s0, 80);
  endtask

  task automatic t_sleep();
    int t0;
    sleep = 1'b1;
    wait_vol(0);
    chk_eq("R6 on at floor", sw_en, 1);
    t0 = ticks_seen;
    while (sw_en) @(negedge clk);
    chk_rng("R6 stop delay ticks", ticks_seen - t0, 1, 2);
    wait_ticks(5);
    chk_eq("R6 silent in sleep", vol, 0);
    sleep = 1'b0;
    t0 = ticks_seen;
    while (!sw_en) @(negedge clk);
    chk_rng("R7 wake ticks", ticks_seen - t0, 1, 2);
    chk_eq("R7 wake at floor", vol, 0);
    wait_vol(190);
  endtask

  task automatic t_shutdown();
    int t0, sw_seen;
    shdn_reg = 1'b1;
    wait_vol(0);
    chk_eq("R6 shdn ramps first", sw_en, 1);
    while (sw_en) @(negedge clk);
    shdn_pin = 1'b1;
    @(negedge clk);
    shdn_reg = 1'b0;
    sw_seen = 0;
    t0 = ticks_seen;
    while (ticks_seen - t0 < 40) begin @(negedge clk); sw_seen |= int'(sw_en); end
    chk_eq("R8 pin alone holds shutdown", sw_seen, 0);
    shdn_pin = 1'b0;
    t0 = ticks_seen;
    while (!sw_en) @(negedge clk);
    chk_rng("R8 restart after both low", ticks_seen - t0, 24, 26);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_startup();
    t_full_ramp_timing();
    t_reverse();
    t_target();
    t_sleep();
    t_shutdown();
    chk_eq("R3 no jumps", jump_errs, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (cycles < WATCHDOG) @(negedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule